// File: doc/BRIEF.md
# Context Bank Stack Controller

This block holds a small last-in first-out stack of hardware context banks. Each bank stores one full processor context: fifteen general registers, a global base register, the two halves of the multiply-accumulate result and the procedure return register. When the processor accepts an interrupt that is permitted to use the banks, the block pushes the presented context into the next free bank. When the processor executes a bank restore, the block pops the most recently saved bank and presents it for loading back into the register file.

A level counter tracks how many banks are occupied, from 0 (nothing saved) to the bank count (every bank full). Pushing onto a full stack is an overflow. It is reported as an error only when the overflow enable bit is set; otherwise the push is dropped silently. Popping an empty stack is an underflow and is always reported. An error leaves the level and the stored banks untouched and raises a one-cycle error pulse with a cause bit. The level and the enable bit are visible on outputs, and the enable bit is written through a simple write strobe.

Top module: `regbank_ctrl`

## Requirements
- R1: After reset the level is 0, the overflow enable is 0, err_pulse and ctx_valid are 0 and ctx_out is all zeros.
- R2: A save request while the level is below the bank count writes ctx_in into the bank at index level, and the level rises by one in the cycle after the request.
- R3: A restore request (with no save request in the same cycle) while the level is above 0 lowers the level by one. In the next cycle ctx_valid is 1 for one cycle and ctx_out carries the bank at the new level.
- R4: Saves and restores interleave in last-in first-out order: each restore returns the context of the most recent save that has not yet been restored.
- R5: A save request at full level with the overflow enable at 1 gives err_pulse = 1 with err_cause = 0 (overflow) in the next cycle. The level stays at the bank count, and no bank is written.
- R6: A save request at full level with the overflow enable at 0 gives no error and no write, and the level stays at the bank count.
- R7: A restore request at level 0 gives err_pulse = 1 with err_cause = 1 (underflow) in the next cycle. ctx_valid stays 0, ctx_out keeps its previous value, and the level stays 0.
- R8: err_pulse is a single-cycle pulse. It is 1 only in the cycle after an overflow or underflow request.
- R9: When cfg_we is 1, cfg_ovf_en is stored as the overflow enable, and it is visible on ovf_en in the next cycle. A save request in the same cycle is judged with the old enable value.
- R10: When a save request and a restore request arrive in the same cycle, only the save is acted on. The restore gives no ctx_valid and no underflow error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_req | input | 1 | Bank-enabled interrupt accepted: push ctx_in |
| restore_req | input | 1 | Restore instruction executed: pop a bank |
| ctx_in | input | DATA_W*(GPR_COUNT+4) | Context to save; word 0 is R0, followed by the other general registers, then base, MAC high, MAC low and return register |
| cfg_we | input | 1 | Write strobe for the overflow enable |
| cfg_ovf_en | input | 1 | Overflow enable value to write |
| ctx_out | output | DATA_W*(GPR_COUNT+4) | Restored context, same layout as ctx_in |
| ctx_valid | output | 1 | One-cycle strobe: ctx_out holds a restored bank |
| bank_level | output | $clog2(NUM_BANKS+1) | Number of occupied banks |
| ovf_en | output | 1 | Current overflow enable |
| err_pulse | output | 1 | One-cycle bank error request |
| err_cause | output | 1 | 0 = overflow, 1 = underflow; meaningful while err_pulse is 1 |

## Verification
The bench fills the stack to the top and then pushes again, once with the enable set and once with it cleared. A design that wraps the counter or overwrites the top bank fails the later pops, and one that ignores the enable reports an error where none is due. It pops past empty to catch a counter that wraps down or a ctx_out that changes on underflow. It also issues save and restore together, and writes the enable in the same cycle as an overflowing push, to expose a wrong priority or a write that takes effect a cycle too early. Long random runs of pushes and pops, checked against a model stack, expose a wrong index (off by one in either direction) on save or restore.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;
   typedef enum logic {
      CAUSE_OVF = 1'b0,
      CAUSE_UNF = 1'b1
   } rb_cause_e;

   // words per context beyond the general registers: base, mac hi, mac lo, return
   localparam int unsigned EXTRA_WORDS = 4;
endpackage

// File: rtl/regbank_level.sv
`timescale 1ns/1ps
module regbank_level #(
   parameter int unsigned NUM_BANKS = 15,
   parameter int unsigned LVL_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             save_req,
   input  logic             restore_req,
   input  logic             cfg_we,
   input  logic             cfg_ovf_en,
   output logic [LVL_W-1:0] level_o,
   output logic             ovf_en_o,
   output logic             save_ok,
   output logic             restore_ok,
   output logic             ovf_hit,
   output logic             unf_hit,
   output logic [LVL_W-1:0] wr_idx,
   output logic [LVL_W-1:0] rd_idx
);
   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(NUM_BANKS);

   logic [LVL_W-1:0] level_q;
   logic             en_q;
   logic             full, empty, pop_req;

   assign full    = (level_q == FULL_LVL);
   assign empty   = (level_q == '0);
   assign pop_req = restore_req && !save_req;

   assign save_ok    = save_req && !full;
   assign restore_ok = pop_req && !empty;
   assign ovf_hit    = save_req && full && en_q;
   assign unf_hit    = pop_req && empty;
   assign wr_idx     = level_q;
   assign rd_idx     = level_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
      end else if (save_ok) begin
         level_q <= level_q + 1'b1;
      end else if (restore_ok) begin
         level_q <= level_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (cfg_we) en_q <= cfg_ovf_en;
   end

   assign level_o  = level_q;
   assign ovf_en_o = en_q;

   // R2
   save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      save_ok |=> level_q == $past(level_q) + 1'b1);
   // R3
   restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restore_ok |=> level_q == $past(level_q) - 1'b1);
   // R6
   silent_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (save_req && full && !en_q) |=> level_q == FULL_LVL);
   // R2
   level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= FULL_LVL);
endmodule

// File: rtl/regbank_store.sv
`timescale 1ns/1ps
module regbank_store #(
   parameter int unsigned NUM_BANKS      = 15,
   parameter int unsigned CTX_W          = 608,
   parameter int unsigned LVL_W          = 4,
   parameter bit          CLEAR_ON_RESET = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LVL_W-1:0] wr_idx,
   input  logic [CTX_W-1:0] wr_data,
   input  logic [LVL_W-1:0] rd_idx,
   output logic [CTX_W-1:0] rd_data
);
   logic [NUM_BANKS*CTX_W-1:0] bank_flat;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [CTX_W-1:0] slot_q;
      logic             hit;
      assign hit = wr_en && (wr_idx == LVL_W'(b));
      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   slot_q <= '0;
            else if (hit) slot_q <= wr_data;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) slot_q <= wr_data;
         end
      end
      assign bank_flat[b*CTX_W +: CTX_W] = slot_q;
   end

   always_comb begin
      rd_data = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_idx == LVL_W'(b)) rd_data = bank_flat[b*CTX_W +: CTX_W];
      end
   end
endmodule

// File: rtl/regbank_errgen.sv
`timescale 1ns/1ps
module regbank_errgen
   import regbank_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ovf_hit,
   input  logic unf_hit,
   output logic err_o,
   output logic cause_o
);
   logic      err_q;
   rb_cause_e cause_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q   <= 1'b0;
         cause_q <= CAUSE_OVF;
      end else begin
         err_q <= ovf_hit || unf_hit;
         if (unf_hit)      cause_q <= CAUSE_UNF;
         else if (ovf_hit) cause_q <= CAUSE_OVF;
      end
   end

   assign err_o   = err_q;
   assign cause_o = cause_q;

   // R8
   one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_hit && unf_hit));
endmodule

// File: rtl/regbank_ctrl.sv
`timescale 1ns/1ps
module regbank_ctrl
   import regbank_pkg::*;
#(
   parameter int unsigned NUM_BANKS      = 15,
   parameter int unsigned GPR_COUNT      = 15,
   parameter int unsigned DATA_W         = 32,
   parameter bit          CLEAR_ON_RESET = 1'b0,
   localparam int unsigned WORDS = GPR_COUNT + EXTRA_WORDS,
   localparam int unsigned CTX_W = DATA_W * WORDS,
   localparam int unsigned LVL_W = $clog2(NUM_BANKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             save_req,
   input  logic             restore_req,
   input  logic [CTX_W-1:0] ctx_in,
   input  logic             cfg_we,
   input  logic             cfg_ovf_en,
   output logic [CTX_W-1:0] ctx_out,
   output logic             ctx_valid,
   output logic [LVL_W-1:0] bank_level,
   output logic             ovf_en,
   output logic             err_pulse,
   output logic             err_cause
);
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("regbank_ctrl: NUM_BANKS must be at least 1");
   end
   if (GPR_COUNT < 1) begin : g_bad_gpr
      $error("regbank_ctrl: GPR_COUNT must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("regbank_ctrl: DATA_W must be at least 1");
   end

   logic             save_ok, restore_ok, ovf_hit, unf_hit;
   logic [LVL_W-1:0] wr_idx, rd_idx;
   logic [CTX_W-1:0] rd_data;
   logic [CTX_W-1:0] out_q;
   logic             vld_q;

   regbank_level #(.NUM_BANKS(NUM_BANKS), .LVL_W(LVL_W)) u_level (
      .clk        (clk),
      .rst_n      (rst_n),
      .save_req   (save_req),
      .restore_req(restore_req),
      .cfg_we     (cfg_we),
      .cfg_ovf_en (cfg_ovf_en),
      .level_o    (bank_level),
      .ovf_en_o   (ovf_en),
      .save_ok    (save_ok),
      .restore_ok (restore_ok),
      .ovf_hit    (ovf_hit),
      .unf_hit    (unf_hit),
      .wr_idx     (wr_idx),
      .rd_idx     (rd_idx)
   );

   regbank_store #(
      .NUM_BANKS(NUM_BANKS), .CTX_W(CTX_W), .LVL_W(LVL_W),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (save_ok),
      .wr_idx (wr_idx),
      .wr_data(ctx_in),
      .rd_idx (rd_idx),
      .rd_data(rd_data)
   );

   regbank_errgen u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .ovf_hit(ovf_hit),
      .unf_hit(unf_hit),
      .err_o  (err_pulse),
      .cause_o(err_cause)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= restore_ok;
         if (restore_ok) out_q <= rd_data;
      end
   end

   assign ctx_out   = out_q;
   assign ctx_valid = vld_q;

   // R5
   ovf_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_hit |=> err_pulse && (err_cause == CAUSE_OVF) && $stable(bank_level));
   // R7
   unf_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf_hit |=> err_pulse && (err_cause == CAUSE_UNF) && !ctx_valid && $stable(ctx_out));
   // R10
   save_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (save_req && restore_req) |=> !ctx_valid);
   // R8
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_hit || unf_hit) |=> !err_pulse);
endmodule

// File: tb/tb_regbank_ctrl.sv
`timescale 1ns/1ps
module tb_regbank_ctrl;
   localparam int NB    = 15;
   localparam int WORDS = 19;
   localparam int CW    = 32 * WORDS;
   localparam int LW    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          save_req = 1'b0, restore_req = 1'b0, cfg_we = 1'b0, cfg_ovf_en = 1'b0;
   logic [CW-1:0] ctx_in = '0;
   logic [CW-1:0] ctx_out;
   logic          ctx_valid, ovf_en, err_pulse, err_cause;
   logic [LW-1:0] bank_level;

   int tests = 0;
   int fails = 0;

   logic [CW-1:0] m_bank [NB];
   int            m_level = 0;
   bit            m_en = 1'b0;
   logic [CW-1:0] m_out = '0;

   always #10 clk = ~clk;

   regbank_ctrl dut (
      .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
      .ctx_in(ctx_in), .cfg_we(cfg_we), .cfg_ovf_en(cfg_ovf_en), .ctx_out(ctx_out),
      .ctx_valid(ctx_valid), .bank_level(bank_level), .ovf_en(ovf_en),
      .err_pulse(err_pulse), .err_cause(err_cause)
   );

   function automatic logic [CW-1:0] rand_ctx();
      logic [CW-1:0] r;
      for (int i = 0; i < WORDS; i++) r[i*32 +: 32] = $urandom;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_ctx(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s ctx_out: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_op(input bit s, input bit r, input bit w, input bit wd,
                         input logic [CW-1:0] c, input string req);
      bit e_err = 0, e_cause = 0, e_vld = 0;
      if (s) begin
         if (m_level < NB) begin
            m_bank[m_level] = c;
            m_level++;
         end else if (m_en) begin
            e_err = 1; e_cause = 0;
         end
      end else if (r) begin
         if (m_level > 0) begin
            m_level--;
            m_out = m_bank[m_level];
            e_vld = 1;
         end else begin
            e_err = 1; e_cause = 1;
         end
      end
      if (w) m_en = wd;
      @(negedge clk);
      save_req = s; restore_req = r; cfg_we = w; cfg_ovf_en = wd; ctx_in = c;
      @(posedge clk);
      #2;
      save_req = 0; restore_req = 0; cfg_we = 0; cfg_ovf_en = 0;
      chk(bank_level == LW'(m_level), req, "bank_level", bank_level, m_level);
      chk(ovf_en == m_en, req, "ovf_en", ovf_en, m_en);
      chk(err_pulse == e_err, req, "err_pulse", err_pulse, e_err);
      if (e_err) chk(err_cause == e_cause, req, "err_cause", err_cause, e_cause);
      chk(ctx_valid == e_vld, req, "ctx_valid", ctx_valid, e_vld);
      chk_ctx(req, ctx_out, m_out);
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk(bank_level == 0, "R1", "bank_level", bank_level, 0);
      chk(ovf_en == 0, "R1", "ovf_en", ovf_en, 0);
      chk(err_pulse == 0, "R1", "err_pulse", err_pulse, 0);
      chk(ctx_valid == 0, "R1", "ctx_valid", ctx_valid, 0);
      chk_ctx("R1", ctx_out, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9 enable write
      run_op(0, 0, 1, 1, '0, "R9");
      // R2 fill the stack
      for (int i = 0; i < NB; i++) run_op(1, 0, 0, 0, rand_ctx(), "R2");
      // R3 pop one, push it back
      run_op(0, 1, 0, 0, '0, "R3");
      run_op(1, 0, 0, 0, rand_ctx(), "R2");
      // R5 overflow reported, nothing written
      run_op(1, 0, 0, 0, rand_ctx(), "R5");
      // R8 error lasts one cycle
      run_op(0, 0, 0, 0, '0, "R8");
      // R9 clear enable in same cycle as overflow: old enable still reports
      run_op(1, 0, 1, 0, rand_ctx(), "R9");
      // R6 silent overflow
      run_op(1, 0, 0, 0, rand_ctx(), "R6");
      run_op(1, 0, 0, 0, rand_ctx(), "R6");
      // R4 drain in LIFO order
      for (int i = 0; i < NB; i++) run_op(0, 1, 0, 0, '0, "R4");
      // R7 underflow, twice
      run_op(0, 1, 0, 0, '0, "R7");
      run_op(0, 1, 0, 0, '0, "R7");
      run_op(0, 0, 0, 0, '0, "R8");
      // R10 simultaneous requests: save wins
      run_op(1, 1, 0, 0, rand_ctx(), "R10");
      run_op(1, 1, 0, 0, rand_ctx(), "R10");
      run_op(0, 1, 0, 0, '0, "R10");

      // R4 random mix against the model
      for (int n = 0; n < 600; n++) begin
         int unsigned p;
         p = $urandom % 100;
         if (p < 45)      run_op(1, 0, 0, 0, rand_ctx(), "R4");
         else if (p < 87) run_op(0, 1, 0, 0, '0, "R4");
         else if (p < 94) run_op(0, 0, 1, 1'($urandom), '0, "R9");
         else if (p < 97) run_op(1, 1, 0, 0, rand_ctx(), "R10");
         else             run_op(0, 0, 0, 0, '0, "R8");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule